// File: doc/BRIEF.md
# Parallel CRC-8 Generator and Word Checker

This block computes an 8-bit cyclic redundancy check over a 16-bit data word in a single combinational pass, with no clock and no stored state. Every check bit is formed as a fixed XOR of selected data bits. The selection comes from the remainder that each data bit leaves when it is divided by the generator polynomial x^8 + x^2 + x + 1. Adjacent data bits are XORed in pairs once, and those pair terms are shared across all check bits, which removes duplicate gates.

A second output compares the computed check value with an 8-bit check value received alongside the word. The two values are XORed bit by bit, and the eight difference bits are NOR-reduced to one flag that is high only when the word is intact. A build parameter selects the implementation. The default is the flattened equations. The alternative is a cascade of sixteen one-bit division stages, which must produce the same results.

Top module: `crc8_par_unit`

## Requirements
- R1: `checkOut` equals the remainder of dataIn·x^8 divided by x^8 + x^2 + x + 1 (polynomial constant 0x07). The remainder starts from zero, with no reflection and no final inversion. dataIn[15] is the highest-degree coefficient and checkOut[7] is the x^7 coefficient. For example, dataIn = 0x0001 gives 0x07.
- R2: Both outputs are purely combinational. They settle to their new values after an input change without any clock edge.
- R3: The cascaded-stage variant (CHAIN_MODE = 1) produces the same `checkOut` and `checkOk` as the flattened variant for every data word and received value.
- R4: `checkOk` is 1 exactly when `rxCheck` equals the computed check value. Otherwise it is 0.
- R5: An all-zero data word gives `checkOut` = 0x00, and with an all-zero `rxCheck` it reports `checkOk` = 1.
- R6: Starting from a matching pair, inverting any single bit of `dataIn` or of `rxCheck` drives `checkOk` to 0.
- R7: Any data word with exactly one bit set gives a nonzero `checkOut`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| dataIn | input | 16 | Data word to protect or verify |
| rxCheck | input | 8 | Check value received with the word |
| checkOut | output | 8 | Computed CRC-8 of `dataIn` |
| checkOk | output | 1 | High when `rxCheck` matches the computed check value |

## Verification
Every one of the 65,536 data words is applied to both variants at once, and each result is compared against a long-division remainder that the bench computes by itself. A wrong tap in a check-bit mask, or a reversed data-bit order, therefore fails on some word. A wrongly shared pair term fails in the same way. For each word the bench also presents the matching check value, which must be accepted, and a copy with one bit inverted, which must be rejected. This catches a compare path that ignores one of the eight bits, or a reduction that ANDs instead of NORs. Single-bit data words and data-bit flips against a fixed received value target the two weak spots of a mask error: a remainder of zero for a lone bit, and an error that goes undetected.

// File: rtl/crc8_pkg.sv
package crc8_pkg;

  // Mask of data bits feeding check bit outBit: bit j set when x^(j+crcW) mod poly has outBit set
  function automatic logic [63:0] eqnMask(int crcW, logic [63:0] poly, int dataW, int outBit);
    logic [63:0] rem;
    logic [63:0] keep;
    logic [63:0] sel;
    logic        topBit;
    keep = (64'd1 << crcW) - 64'd1;
    rem  = 64'd1;
    sel  = '0;
    for (int s = 0; s < crcW; s++) begin
      topBit = rem[crcW-1];
      rem    = (rem << 1) & keep;
      if (topBit) rem = rem ^ (poly & keep);
    end
    for (int j = 0; j < dataW; j++) begin
      sel[j] = rem[outBit];
      topBit = rem[crcW-1];
      rem    = (rem << 1) & keep;
      if (topBit) rem = rem ^ (poly & keep);
    end
    return sel;
  endfunction

endpackage

// File: rtl/crc8_flat_core.sv
module crc8_flat_core #(
  parameter int              DATA_W = 16,
  parameter int              CRC_W  = 8,
  parameter logic [CRC_W-1:0] POLY  = 8'h07
) (
  input  logic [DATA_W-1:0] dataIn,
  output logic [CRC_W-1:0]  checkOut
);
  localparam int PAIRS   = DATA_W / 2;
  localparam int ODD     = DATA_W % 2;
  localparam int N_TERMS = PAIRS + ODD;

  // Shared partial XORs: one per adjacent pair of data bits
  logic [PAIRS-1:0] pairX;
  for (genvar p = 0; p < PAIRS; p++) begin : gPairX
    assign pairX[p] = dataIn[2*p] ^ dataIn[2*p+1];
  end

  for (genvar i = 0; i < CRC_W; i++) begin : gBit
    localparam logic [63:0] M = crc8_pkg::eqnMask(CRC_W, 64'(POLY), DATA_W, i);
    logic [N_TERMS-1:0] terms;
    for (genvar p = 0; p < PAIRS; p++) begin : gTerm
      if (M[2*p] && M[2*p+1]) begin : gBoth
        assign terms[p] = pairX[p];
      end else if (M[2*p]) begin : gLow
        assign terms[p] = dataIn[2*p];
      end else if (M[2*p+1]) begin : gHigh
        assign terms[p] = dataIn[2*p+1];
      end else begin : gNone
        assign terms[p] = 1'b0;
      end
    end
    if (ODD == 1) begin : gOdd
      assign terms[N_TERMS-1] = M[DATA_W-1] ? dataIn[DATA_W-1] : 1'b0;
    end
    assign checkOut[i] = ^terms;
  end
endmodule

// File: rtl/crc8_chain_core.sv
module crc8_chain_core #(
  parameter int              DATA_W = 16,
  parameter int              CRC_W  = 8,
  parameter logic [CRC_W-1:0] POLY  = 8'h07
) (
  input  logic [DATA_W-1:0] dataIn,
  output logic [CRC_W-1:0]  checkOut
);
  logic [CRC_W-1:0] stage [DATA_W+1];
  assign stage[0] = '0;

  // One division step per data bit, most significant bit first
  for (genvar k = 0; k < DATA_W; k++) begin : gStage
    logic feedBack;
    assign feedBack   = stage[k][CRC_W-1] ^ dataIn[DATA_W-1-k];
    assign stage[k+1] = {stage[k][CRC_W-2:0], 1'b0} ^ (feedBack ? POLY : '0);
  end

  assign checkOut = stage[DATA_W];
endmodule

// File: rtl/crc8_match.sv
module crc8_match #(
  parameter int CRC_W = 8
) (
  input  logic [CRC_W-1:0] calcCheck,
  input  logic [CRC_W-1:0] rxCheck,
  output logic             checkOk
);
  logic [CRC_W-1:0] diffBits;
  assign diffBits = calcCheck ^ rxCheck;
  assign checkOk  = ~(|diffBits);
endmodule

// File: rtl/crc8_par_unit.sv
module crc8_par_unit #(
  parameter int              DATA_W     = 16,
  parameter int              CRC_W      = 8,
  parameter logic [CRC_W-1:0] POLY      = 8'h07,
  parameter bit              CHAIN_MODE = 1'b0
) (
  input  logic [DATA_W-1:0] dataIn,
  input  logic [CRC_W-1:0]  rxCheck,
  output logic [CRC_W-1:0]  checkOut,
  output logic              checkOk
);
  logic [CRC_W-1:0] calcCheck;

  if (CHAIN_MODE) begin : gChain
    crc8_chain_core #(.DATA_W(DATA_W), .CRC_W(CRC_W), .POLY(POLY)) uCore (
      .dataIn(dataIn), .checkOut(calcCheck));
  end else begin : gFlat
    crc8_flat_core #(.DATA_W(DATA_W), .CRC_W(CRC_W), .POLY(POLY)) uCore (
      .dataIn(dataIn), .checkOut(calcCheck));
  end

  crc8_match #(.CRC_W(CRC_W)) uMatch (
    .calcCheck(calcCheck), .rxCheck(rxCheck), .checkOk(checkOk));

  assign checkOut = calcCheck;
endmodule

// File: rtl/crc8_par_unit_chk.sv
module crc8_par_unit_chk #(
  parameter int              DATA_W     = 16,
  parameter int              CRC_W      = 8,
  parameter logic [CRC_W-1:0] POLY      = 8'h07,
  parameter bit              CHAIN_MODE = 1'b0
) (
  input logic [DATA_W-1:0] dataIn,
  input logic [CRC_W-1:0]  rxCheck,
  input logic [CRC_W-1:0]  checkOut,
  input logic              checkOk
);
  logic [CRC_W-1:0] refCheck;

  // Reference is the variant the instance did not build
  if (CHAIN_MODE) begin : gRefFlat
    crc8_flat_core #(.DATA_W(DATA_W), .CRC_W(CRC_W), .POLY(POLY)) uRef (
      .dataIn(dataIn), .checkOut(refCheck));
  end else begin : gRefChain
    crc8_chain_core #(.DATA_W(DATA_W), .CRC_W(CRC_W), .POLY(POLY)) uRef (
      .dataIn(dataIn), .checkOut(refCheck));
  end

  always_comb begin
    AST_VARIANT_AGREE: assert (checkOut == refCheck); // R3
    AST_OK_IFF_EQUAL: assert (checkOk == (rxCheck == refCheck)); // R4
    AST_ZERO_WORD: assert (!(dataIn == '0 && rxCheck == '0) || checkOk); // R5
    AST_LONE_BIT_NONZERO: assert (!($countones(dataIn) == 1) || checkOut != '0); // R7
  end
endmodule

bind crc8_par_unit crc8_par_unit_chk #(
  .DATA_W(DATA_W), .CRC_W(CRC_W), .POLY(POLY), .CHAIN_MODE(CHAIN_MODE)
) uChk (
  .dataIn(dataIn), .rxCheck(rxCheck), .checkOut(checkOut), .checkOk(checkOk));

// File: tb/sim_crc8_par_unit.sv
module sim_crc8_par_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] dataIn = '0;
  logic [7:0]  rxCheck = '0;
  logic [7:0]  outFlat, outChain;
  logic        okFlat, okChain;
  int          checkCount = 0;
  int          failCount = 0;
  bit          finished = 1'b0;

  always #5 clk = ~clk;

  crc8_par_unit #(.CHAIN_MODE(1'b0)) u0 (
    .dataIn(dataIn), .rxCheck(rxCheck), .checkOut(outFlat), .checkOk(okFlat));
  crc8_par_unit #(.CHAIN_MODE(1'b1)) u1 (
    .dataIn(dataIn), .rxCheck(rxCheck), .checkOut(outChain), .checkOk(okChain));

  // Long division over GF(2) with 9-bit generator 0x107
  function automatic logic [7:0] expCrc(logic [15:0] d);
    logic [23:0] acc;
    acc = {d, 8'h00};
    for (int b = 23; b >= 8; b--) begin
      if (acc[b]) acc = acc ^ (24'h107 << (b - 8));
    end
    return acc[7:0];
  endfunction

  task automatic check(bit ok, string req, int act, int exp, logic [15:0] d);
    checkCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s data=%h actual=%h expected=%h", req, d, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R5: zero word, zero received value
    check(outFlat == 8'h00, "R5", outFlat, 8'h00, dataIn);
    check(okFlat == 1'b1, "R5", okFlat, 1, dataIn);
    check(okChain == 1'b1, "R5", okChain, 1, dataIn);

    // R1: known value, R2: settles without a clock edge
    @(posedge clk);
    #1 dataIn = 16'h0001; rxCheck = 8'h00;
    #2 check(outFlat == 8'h07, "R1", outFlat, 8'h07, dataIn);
    check(okFlat == 1'b0, "R2", okFlat, 0, dataIn);
    rxCheck = 8'h07;
    #1 check(okFlat == 1'b1, "R2", okFlat, 1, dataIn);

    // Exhaustive sweep: R1, R3, R4, R6 on received value
    for (int v = 0; v < 65536; v++) begin
      logic [7:0] e;
      logic [7:0] bad;
      @(posedge clk);
      e = expCrc(16'(v));
      #1 dataIn = 16'(v); rxCheck = e;
      #2;
      check(outFlat == e, "R1", outFlat, e, dataIn);
      check(outChain == e, "R3", outChain, e, dataIn);
      check(okFlat == 1'b1, "R4", okFlat, 1, dataIn);
      check(okChain == okFlat, "R3", okChain, okFlat, dataIn);
      bad = e ^ (8'h01 << (v % 8));
      rxCheck = bad;
      #2;
      check(okFlat == 1'b0, "R6", okFlat, 0, dataIn);
      check(okChain == 1'b0, "R6", okChain, 0, dataIn);
      if ((v & (v - 1)) == 0 && v != 0)
        check(outFlat != 8'h00, "R7", outFlat, 1, dataIn);
    end

    // R6: single data-bit flips against a fixed received value
    for (int base = 0; base < 4; base++) begin
      logic [15:0] w;
      w = (base == 0) ? 16'h0000 : (base == 1) ? 16'hFFFF : (base == 2) ? 16'hA5C3 : 16'h1234;
      for (int b = 0; b < 16; b++) begin
        @(posedge clk);
        #1 dataIn = w ^ (16'h0001 << b); rxCheck = expCrc(w);
        #2 check(okFlat == 1'b0, "R6", okFlat, 0, dataIn);
        check(okChain == 1'b0, "R6", okChain, 0, dataIn);
      end
    end

    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checkCount++;
      failCount++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      summary();
      $finish;
    end
  end
endmodule